// File: doc/BRIEF.md
# Configurable SPI Master Transfer Engine

This block is a single-channel SPI master that moves one data word per request. Each request carries its own format: SCLK idle level, which SCLK edge launches and which captures data, a clock divider, a word length from 2 to 16 bits, a half-duplex switch and a switch that bypasses the chip-select setup and hold delays. The engine takes a copy of the whole format when it accepts a request, while chip select is still high. Later changes on the format inputs therefore cannot disturb a word in flight, and the SCLK idle level only moves while no slave is selected.

A request is one `start` pulse while `busy` is low. The engine then pulls `cs_n` low and waits out the setup delay. It shifts the word MSB first, waits out the hold delay and releases `cs_n`. One cycle later it pulses `done` and presents the received bits on `rx_data`. In half-duplex mode the master never drives the MOSI line and captures the slave's bits from it. A word length outside the legal range produces a one-cycle `fmt_err` pulse, and no transfer is started.

Top module: `spi_xfer_engine`

## Requirements
- R1: One SCLK period lasts D system clock cycles, with D = prescale + 1. A prescale of 0 gives D = 2. Each bit takes D cycles: the launch half lasts floor(D/2) cycles and the capture half lasts the rest. The time from CS falling to CS rising is S + len*D + H + 2 cycles, where S and H are the setup and hold counts in effect.
- R2: SCLK sits at the latched polarity whenever CS falls or rises: low for polarity 0 and high for polarity 1.
- R3: With phase 0, SCLK leaves its idle level to launch each bit and returns to idle to capture it, so one word makes 2*len edges. The first edge comes S+1 cycles after CS falls.
- R4: With phase 1, bit 0 is on the line half a period before the first SCLK edge. Both sides capture on the edges that leave idle, and the first edge comes S+1+floor(D/2) cycles after CS falls.
- R5: A length field from 2 to 16 is legal. The transmit word is right-aligned in `tx_data` and is sent MSB first. The received bits come out right-aligned in `rx_data` with zeros above them.
- R6: A start request with length 0, 1 or any value above 16 pulses `fmt_err` for one cycle. CS stays high and `busy` stays low.
- R7: In half-duplex mode `mosi_oe` stays low for the whole transfer, and receive bits are taken from `mosi_i` instead of `miso`.
- R8: With the delays enabled, a setup count S adds S cycles between CS falling and the first SCLK edge. A count of 0 adds nothing.
- R9: With the delays enabled, a hold count H adds H cycles after the last SCLK edge before CS rises. With phase 0 that gap is H+1+(D-floor(D/2)) cycles; with phase 1 it is H+1 cycles.
- R10: When the bypass bit is set, both delays count as 0, whatever the setup and hold inputs hold.
- R11: `busy` rises with the accepted start and falls with `done`. `done` is a one-cycle pulse one cycle after CS rises. A start seen while `busy` is high has no effect.
- R12: The format, the delay counts and the transmit word are latched when a start is accepted. Changes on those inputs during a transfer do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request pulse |
| tx_data | input | 16 | Word to send, right-aligned |
| fmt_cpol | input | 1 | SCLK idle level |
| fmt_cpha | input | 1 | 0: launch on first edge; 1: bit 0 set up before first edge |
| fmt_prescale | input | 8 | Divider field, period = value+1 (0 acts as 2) |
| fmt_len | input | 5 | Word length in bits, 2 to 16 legal |
| fmt_half_duplex | input | 1 | Receive on the MOSI line, never drive it |
| fmt_no_cs_delay | input | 1 | Bypass setup and hold delays |
| setup_dly | input | 8 | Cycles between CS fall and first edge |
| hold_dly | input | 8 | Cycles between last edge and CS rise |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | One-cycle pulse for an illegal length |
| rx_data | output | 16 | Received word, right-aligned |
| sclk | output | 1 | SPI clock |
| mosi_o | output | 1 | MOSI output value |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | MOSI line read back (half-duplex receive) |
| miso | input | 1 | Slave data input |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with its default widths: a 16-bit word, a 5-bit length field and 8-bit divider and delay counts. With these widths every legal length, the prescale values 0 and 1 (which both give a two-cycle period), odd divisors with unequal halves and the largest divider of 256 can all be reached. The 5-bit length field can also hold the illegal values 0, 1, 17 and 31. A slave model in the bench drives and captures data on the edges that the phase setting defines, and it swaps the MISO and MOSI lines in half-duplex mode. Edge counts, gaps and received words therefore expose timing slips of a single cycle in either direction.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_FIN
  } xfer_state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic hdx;
  } fmt_flags_t;

endpackage

// File: rtl/spi_fmt_decode.sv
module spi_fmt_decode #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int PRE_W  = 8
) (
  input  logic [LEN_W-1:0] len,
  input  logic [PRE_W-1:0] prescale,
  output logic             len_ok,
  output logic [PRE_W:0]   half_a,
  output logic [PRE_W:0]   half_b
);
  localparam int HW = PRE_W + 1;

  logic [HW-1:0] div;

  always_comb begin
    div    = (prescale == '0) ? HW'(2) : ({1'b0, prescale} + HW'(1));
    half_a = div >> 1;
    half_b = div - half_a;
    len_ok = (int'(len) >= 2) && (int'(len) <= DATA_W);
  end

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len,
  input  logic              shift_tx,
  input  logic              sample,
  input  logic              rx_bit,
  output logic              tx_msb,
  output logic [DATA_W-1:0] rx_word
);
  localparam int AW = LEN_W + 1;

  logic [DATA_W-1:0] tx_sh;
  logic [AW-1:0]     align;

  assign align  = AW'(DATA_W) - {1'b0, len};
  assign tx_msb = tx_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      rx_word <= '0;
    end else if (load) begin
      tx_sh   <= tx_word << align;
      rx_word <= '0;
    end else begin
      if (shift_tx) tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
      if (sample)   rx_word <= {rx_word[DATA_W-2:0], rx_bit};
    end
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int PRE_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              fmt_cpol,
  input  logic              fmt_cpha,
  input  logic [PRE_W-1:0]  fmt_prescale,
  input  logic [LEN_W-1:0]  fmt_len,
  input  logic              fmt_half_duplex,
  input  logic              fmt_no_cs_delay,
  input  logic [DLY_W-1:0]  setup_dly,
  input  logic [DLY_W-1:0]  hold_dly,
  output logic              busy,
  output logic              done,
  output logic              fmt_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso,
  output logic              cs_n
);
  import spi_xfer_pkg::*;

  localparam int HW = PRE_W + 1;
  localparam int KW = LEN_W + 2;

  xfer_state_t       st;
  fmt_flags_t        flags_q;
  logic [LEN_W-1:0]  len_q;
  logic [HW-1:0]     ha_q, hb_q, hcnt;
  logic [KW-1:0]     kcnt, k_nx, last_k;
  logic [DLY_W-1:0]  dly_cnt, hold_q;
  logic              len_ok;
  logic [HW-1:0]     ha_in, hb_in;
  logic              accept, half_end, sh_shift, sh_sample, rx_bit;
  logic [DATA_W-1:0] rx_word;

  spi_fmt_decode #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PRE_W(PRE_W)) u_dec (
    .len(fmt_len), .prescale(fmt_prescale),
    .len_ok(len_ok), .half_a(ha_in), .half_b(hb_in)
  );

  assign accept    = (st == ST_IDLE) && start && len_ok;
  assign half_end  = (st == ST_XFER) && (hcnt == '0);
  assign k_nx      = kcnt + KW'(1);
  assign last_k    = {1'b0, len_q, 1'b0} - KW'(1);
  assign sh_sample = half_end && !kcnt[0];
  assign sh_shift  = half_end && kcnt[0] && (kcnt != last_k);
  assign rx_bit    = flags_q.hdx ? mosi_i : miso;

  spi_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .tx_word(tx_data), .len(fmt_len),
    .shift_tx(sh_shift), .sample(sh_sample), .rx_bit(rx_bit),
    .tx_msb(mosi_o), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      flags_q <= '0;
      len_q   <= '0;
      ha_q    <= '0;
      hb_q    <= '0;
      hcnt    <= '0;
      kcnt    <= '0;
      dly_cnt <= '0;
      hold_q  <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      mosi_oe <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      fmt_err <= 1'b0;
      rx_data <= '0;
    end else begin
      done    <= 1'b0;
      fmt_err <= 1'b0;
      case (st)
        ST_IDLE: begin
          sclk <= fmt_cpol;
          if (start && !len_ok) fmt_err <= 1'b1;
          if (accept) begin
            flags_q <= '{cpol: fmt_cpol, cpha: fmt_cpha, hdx: fmt_half_duplex};
            len_q   <= fmt_len;
            ha_q    <= ha_in;
            hb_q    <= hb_in;
            dly_cnt <= fmt_no_cs_delay ? '0 : setup_dly;
            hold_q  <= fmt_no_cs_delay ? '0 : hold_dly;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            mosi_oe <= !fmt_half_duplex;
            st      <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end else begin
            kcnt <= '0;
            hcnt <= ha_q - HW'(1);
            sclk <= flags_q.cpol ^ ~flags_q.cpha;
            st   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (hcnt != '0) begin
            hcnt <= hcnt - HW'(1);
          end else if (kcnt == last_k) begin
            sclk    <= flags_q.cpol;
            dly_cnt <= hold_q;
            st      <= ST_HOLD;
          end else begin
            kcnt <= k_nx;
            hcnt <= (k_nx[0] ? hb_q : ha_q) - HW'(1);
            sclk <= flags_q.cpol ^ (k_nx[0] ~^ flags_q.cpha);
          end
        end
        ST_HOLD: begin
          if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end else begin
            cs_n    <= 1'b1;
            mosi_oe <= 1'b0;
            st      <= ST_FIN;
          end
        end
        ST_FIN: begin
          done    <= 1'b1;
          busy    <= 1'b0;
          rx_data <= rx_word;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: done follows a cycle in which CS was already released
  assert_done_after_cs_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(cs_n)));

  // R11: a selected slave always implies an active transfer
  assert_cs_implies_busy_R11: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R7: no MOSI drive during a half-duplex transfer
  assert_hdx_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && flags_q.hdx) |-> !mosi_oe);

  // R6: an error pulse never accompanies a transfer
  assert_err_no_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (cs_n && !busy));

  // R2: SCLK is idle at both CS transitions
  assert_cs_fall_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk == flags_q.cpol));
  assert_cs_rise_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (sclk == flags_q.cpol));

  // R5: only legal lengths ever get latched for a transfer
  assert_len_legal_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> ((int'(len_q) >= 2) && (int'(len_q) <= DATA_W)));

endmodule

// File: tb/spi_xfer_engine_bench.sv
module spi_xfer_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic fmt_cpol = 1'b0, fmt_cpha = 1'b0, fmt_hdx = 1'b0, fmt_nod = 1'b0;
  logic [7:0] fmt_pre = '0, setup_dly = '0, hold_dly = '0;
  logic [4:0] fmt_len = 5'd8;
  logic busy, done, fmt_err, sclk, mosi_o, mosi_oe, cs_n, miso, mosi_i;
  logic [DW-1:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_engine u_spi_xfer_engine (
    .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
    .fmt_cpol(fmt_cpol), .fmt_cpha(fmt_cpha), .fmt_prescale(fmt_pre),
    .fmt_len(fmt_len), .fmt_half_duplex(fmt_hdx), .fmt_no_cs_delay(fmt_nod),
    .setup_dly(setup_dly), .hold_dly(hold_dly), .busy(busy), .done(done),
    .fmt_err(fmt_err), .rx_data(rx_data), .sclk(sclk), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;
  logic b_cpol = 0, b_cpha = 0, b_hdx = 0, sbit = 0;
  int b_len = 8;
  logic [DW-1:0] b_pat = '0, srx = '0;
  int edges, first_e, last_e, fall_c, rise_c, done_r, done_f, sidx, cs_falls = 0;
  logic lvl_fall, lvl_rise, oe_seen;

  assign miso   = b_hdx ? ~sbit : sbit;
  assign mosi_i = b_hdx ? sbit : ~sbit;

  always @(negedge clk) begin
    cyc++;
    if (cs_n === 1'b0 && mosi_oe === 1'b1) oe_seen = 1;
  end

  always @(negedge cs_n) begin
    cs_falls++; fall_c = cyc; lvl_fall = sclk;
    edges = 0; sidx = 0; srx = '0; oe_seen = 0;
    if (b_cpha) sbit = b_pat[b_len-1];
  end
  always @(posedge cs_n) begin rise_c = cyc; lvl_rise = sclk; end
  always @(posedge done) done_r = cyc;
  always @(negedge done) done_f = cyc;

  // slave model: launch and capture on the edges each phase setting defines
  always @(sclk) begin
    if (cs_n === 1'b0) begin
      edges++;
      if (edges == 1) first_e = cyc;
      last_e = cyc;
      if (sclk !== b_cpol) begin
        if (!b_cpha) begin
          if (sidx < b_len) sbit = b_pat[b_len-1-sidx];
        end else srx = {srx[DW-2:0], mosi_o};
      end else begin
        if (!b_cpha) begin
          srx = {srx[DW-2:0], mosi_o};
          sidx++;
        end else begin
          sidx++;
          if (sidx < b_len) sbit = b_pat[b_len-1-sidx];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int div_of(input int pre);
    return (pre == 0) ? 2 : pre + 1;
  endfunction

  function automatic logic [DW-1:0] mask_of(input int len);
    return DW'((32'd1 << len) - 1);
  endfunction

  task automatic run_xfer(input bit cpol, input bit cpha, input int pre, input int len,
                          input bit hdx, input bit nod, input int s, input int h,
                          input logic [DW-1:0] tx, input logic [DW-1:0] pat,
                          input bit extra_start);
    int d, he, ho, se, hq, t, falls0;
    string ph, sq;
    @(negedge clk);
    fmt_cpol = cpol; fmt_cpha = cpha; fmt_pre = 8'(pre); fmt_len = 5'(len);
    fmt_hdx = hdx; fmt_nod = nod; setup_dly = 8'(s); hold_dly = 8'(h); tx_data = tx;
    b_cpol = cpol; b_cpha = cpha; b_hdx = hdx; b_len = len; b_pat = pat; sbit = 0;
    falls0 = cs_falls;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    // R12: disturb every format input while the word is in flight
    fmt_cpol = ~cpol; fmt_cpha = ~cpha; fmt_pre = 8'($urandom); fmt_len = 5'($urandom);
    fmt_hdx = ~hdx; fmt_nod = ~nod; setup_dly = 8'($urandom); hold_dly = 8'($urandom);
    tx_data = ~tx;
    if (extra_start) begin
      repeat (2) @(negedge clk);
      chk(busy === 1'b1, "R11", "busy during transfer", int'(busy), 1);
      fmt_len = 5'(len); start = 1;
      @(negedge clk); start = 0;
    end
    t = 0;
    while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    d = div_of(pre); he = d / 2; ho = d - he;
    se = nod ? 0 : s; hq = nod ? 0 : h;
    ph = cpha ? "R4" : "R3";
    sq = nod ? "R10" : "R8";
    chk(edges == 2*len, ph, "edge count", edges, 2*len);
    chk(first_e - fall_c == se + 1 + (cpha ? he : 0), sq, "CS fall to first edge",
        first_e - fall_c, se + 1 + (cpha ? he : 0));
    chk(rise_c - last_e == hq + 1 + (cpha ? 0 : ho), nod ? "R10" : "R9",
        "last edge to CS rise", rise_c - last_e, hq + 1 + (cpha ? 0 : ho));
    chk(rise_c - fall_c == se + len*d + hq + 2, "R1 R12", "CS low length",
        rise_c - fall_c, se + len*d + hq + 2);
    chk(lvl_fall === cpol && lvl_rise === cpol, "R2", "SCLK level at CS edges",
        int'({lvl_fall, lvl_rise}), int'({cpol, cpol}));
    chk(rx_data === (pat & mask_of(len)), hdx ? "R7" : "R5", "received word",
        int'(rx_data), int'(pat & mask_of(len)));
    if (hdx) chk(oe_seen == 0, "R7", "MOSI enable in half duplex", int'(oe_seen), 0);
    else     chk(srx === (tx & mask_of(len)), "R5", "word seen by slave",
                 int'(srx), int'(tx & mask_of(len)));
    chk(done_r - rise_c == 1, "R11", "CS rise to done", done_r - rise_c, 1);
    chk(done_f - done_r == 1, "R11", "done width", done_f - done_r, 1);
    chk(cs_falls == falls0 + 1, "R11", "one transfer per accepted start",
        cs_falls - falls0, 1);
    chk(busy === 1'b0, "R11", "busy after done", int'(busy), 0);
  endtask

  task automatic run_bad(input int len);
    int falls0;
    @(negedge clk);
    fmt_len = 5'(len); falls0 = cs_falls;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(fmt_err === 1'b1, "R6", "error pulse", int'(fmt_err), 1);
    chk(busy === 1'b0 && cs_n === 1'b1, "R6", "no transfer on error",
        int'({busy, cs_n}), 1);
    @(negedge clk);
    chk(fmt_err === 1'b0, "R6", "error pulse width", int'(fmt_err), 0);
    repeat (3) @(negedge clk);
    chk(cs_falls == falls0 && cs_n === 1'b1, "R6", "CS stays high",
        cs_falls - falls0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0 && done === 1'b0 && mosi_oe === 1'b0 &&
        fmt_err === 1'b0 && sclk === 1'b0, "R11", "reset state",
        int'({cs_n, busy, done, mosi_oe, fmt_err, sclk}), 32);

    // directed corners
    run_xfer(0, 0, 0, 8, 0, 0, 0, 0, 16'h00A5, 16'h003C, 0);   // R1 prescale 0
    run_xfer(1, 0, 1, 8, 0, 0, 0, 0, 16'h005A, 16'h00C3, 0);   // R1 prescale 1
    run_xfer(0, 1, 2, 2, 0, 0, 3, 2, 16'h0002, 16'h0001, 0);   // R4 shortest word
    run_xfer(1, 1, 4, 16, 0, 0, 1, 4, 16'hBEEF, 16'h1234, 0);  // R5 longest word
    run_xfer(0, 0, 255, 16, 0, 0, 2, 2, 16'h8001, 16'hF00F, 0);
    run_xfer(1, 0, 3, 11, 1, 0, 1, 1, 16'h07FF, 16'h0555, 0);  // R7
    run_xfer(0, 1, 5, 9, 1, 0, 0, 3, 16'h01AA, 16'h0133, 0);   // R7
    run_xfer(0, 0, 2, 7, 0, 1, 200, 200, 16'h0055, 16'h002A, 0); // R10
    run_xfer(1, 1, 6, 5, 0, 0, 9, 7, 16'h0011, 16'h000E, 0);   // R8 R9
    run_xfer(0, 0, 1, 12, 0, 0, 0, 0, 16'h0ABC, 16'h0123, 1);  // R11 start while busy
    run_bad(0); run_bad(1); run_bad(17); run_bad(31);

    for (int i = 0; i < 40; i++) begin
      run_xfer(1'($urandom), 1'($urandom), ($urandom % 4 == 0) ? int'($urandom % 40) : int'($urandom % 6),
               2 + int'($urandom % 15), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
               int'($urandom % 6), int'($urandom % 6), 16'($urandom), 16'($urandom),
               ($urandom % 5 == 0));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule